// File: doc/BRIEF.md
# Receive Sampling Delay Window Search Sequencer

This block finds a good receive sampling delay for a high-speed card interface. When started, it walks a delay tap setting upward from zero through a fixed count of taps. At each tap it commits the setting to the delay logic and then asks an external agent to run one pass/fail trial at that setting. While it walks, it tracks runs of consecutive passing taps. It remembers the longest run and the tap on which that run ended.

After the last tap it computes the middle of the longest passing run and commits that tap as the final setting. It then signals completion. If no tap passed, or the final setting could not be committed, it signals an error. Every commit uses the same handshake. The sequencer raises an update request with the tap value and waits for the delay logic to acknowledge it. It does this twice per tap, with one idle cycle between the two requests. A commit that draws no acknowledge within a bounded number of cycles counts as a failed tap.

Top module: `tune_window_seq`

## Requirements
- R1: After reset, done_o, err_o, tap_upd_o and trial_req_o are low and tap_o is 0.
- R2: A sweep visits taps 0, 1, ..., NUM_TAPS-1 (default 40) in increasing order. Each tap whose commit succeeds gets exactly one trial. tap_o never holds a value of NUM_TAPS or more.
- R3: A commit raises tap_upd_o with tap_o valid and keeps it high until the clock edge that samples tap_ack_i high. It then holds tap_upd_o low for exactly one cycle and raises it again for a second request at the same tap. trial_req_o rises only in the cycle after the second acknowledge, and tap_upd_o and trial_req_o are never high together.
- R4: If one update request sees no acknowledge for ACK_LIMIT consecutive cycles (default 250), the tap counts as failed. No trial is requested for it, the current run is cleared, and the sweep moves on to the next tap with a new update request in the following cycle.
- R5: A passing trial extends the current run by one. A failing trial clears it. The recorded best run is replaced only by a strictly longer run, so of two equally long runs the earlier one wins.
- R6: After the last tap, the final tap is the end tap of the best run minus half its length, rounded down. It is driven on tap_o and committed with the same two-request handshake.
- R7: done_o is high for exactly one cycle. That cycle is the one after the edge that samples the acknowledge of the final tap's second request.
- R8: If no tap passed, err_o is high for one cycle, right after the last trial result is sampled. No further update request or trial follows.
- R9: If either request of the final commit times out, err_o pulses for one cycle instead of done_o.
- R10: start_i is ignored while a sweep is in progress, and done_o and err_o are never high together.
- R11: trial_req_o stays high with tap_o unchanged until the edge that samples trial_vld_i high. trial_pass_i is used only at that edge, and the next update request follows in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a sweep (sampled while idle) |
| done_o | output | 1 | One-cycle pulse: final tap committed |
| err_o | output | 1 | One-cycle pulse: no passing tap or final commit failed |
| tap_o | output | TAP_W | Delay tap setting being committed or tested |
| tap_upd_o | output | 1 | Update request to the delay logic |
| tap_ack_i | input | 1 | Delay logic has taken the update |
| trial_req_o | output | 1 | Run one pass/fail trial at tap_o |
| trial_vld_i | input | 1 | Trial result valid |
| trial_pass_i | input | 1 | Trial result: 1 means pass |

## Verification
Every result here lands one register after the edge that samples its cause. An acknowledge moves tap_upd_o in the next cycle. A trial result moves tap_o and tap_upd_o in the next cycle. The final acknowledge, a missing pass or a final timeout raises done_o or err_o in the next cycle. A missing acknowledge turns into a failed tap ACK_LIMIT cycles after the request rose. The bench model advances at each rising edge from the same port inputs, and outputs are compared with it at the falling edge, so each expected value is checked in the cycle it is due. Stimulus is driven at the falling edge. Per-sweep checks of the final tap, the trial count and the done/error pulse are made at the falling edge where the pulse is visible.

// File: rtl/tws_pkg.sv
package tws_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_UPD   = 2'd1,
      ST_GAP   = 2'd2,
      ST_TRIAL = 2'd3
   } tws_state_e;

endpackage

// File: rtl/tws_ack_timer.sv
module tws_ack_timer #(
   parameter int unsigned LIMIT = 250,
   localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic ack_i,
   output logic expire_o
);

   generate
      if (LIMIT == 0) begin : g_no_limit
         assign expire_o = 1'b0;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;

         assign expire_o = run_i && !ack_i && (cnt_q == CNT_W'(LIMIT - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run_i || ack_i || expire_o) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tws_streak.sv
module tws_streak #(
   parameter int unsigned TAP_W = 6,
   parameter int unsigned LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             hit_i,
   input  logic             miss_i,
   input  logic [TAP_W-1:0] tap_i,
   output logic [LEN_W-1:0] nxt_len_o,
   output logic [TAP_W-1:0] nxt_end_o
);

   logic [LEN_W-1:0] run_q, best_q, run_d;
   logic [TAP_W-1:0] end_q;

   always_comb begin
      run_d     = run_q;
      nxt_len_o = best_q;
      nxt_end_o = end_q;
      if (miss_i) begin
         run_d = '0;
      end else if (hit_i) begin
         run_d = run_q + 1'b1;
         if (run_d > best_q) begin
            nxt_len_o = run_d;
            nxt_end_o = tap_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         best_q <= '0;
         end_q  <= '0;
      end else if (clr_i) begin
         run_q  <= '0;
         best_q <= '0;
         end_q  <= '0;
      end else begin
         run_q  <= run_d;
         best_q <= nxt_len_o;
         end_q  <= nxt_end_o;
      end
   end

endmodule

// File: rtl/tune_window_seq.sv
module tune_window_seq
   import tws_pkg::*;
#(
   parameter int unsigned TAP_W     = 6,
   parameter int unsigned NUM_TAPS  = 40,
   parameter int unsigned ACK_LIMIT = 250,
   localparam int unsigned LEN_W    = $clog2(NUM_TAPS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             done_o,
   output logic             err_o,
   output logic [TAP_W-1:0] tap_o,
   output logic             tap_upd_o,
   input  logic             tap_ack_i,
   output logic             trial_req_o,
   input  logic             trial_vld_i,
   input  logic             trial_pass_i
);

   generate
      if (NUM_TAPS < 1 || NUM_TAPS > (1 << TAP_W)) begin : g_bad_cfg
         $error("tune_window_seq: tap count does not fit the tap field");
      end
   endgenerate

   tws_state_e       st_q, st_d;
   logic             ph_q, ph_d;
   logic             fin_q, fin_d;
   logic [TAP_W-1:0] tap_q, tap_d;
   logic             done_q, done_d;
   logic             err_q, err_d;
   logic             clr;

   logic             upd_act, expire, trial_done, upd_fail, step, hit, miss, last_tap;
   logic [LEN_W-1:0] nxt_len;
   logic [TAP_W-1:0] nxt_end, centre;

   assign upd_act    = (st_q == ST_UPD);
   assign trial_done = (st_q == ST_TRIAL) && trial_vld_i;
   assign upd_fail   = upd_act && expire && !fin_q;
   assign hit        = trial_done && trial_pass_i;
   assign miss       = (trial_done && !trial_pass_i) || upd_fail;
   assign step       = trial_done || upd_fail;
   assign last_tap   = (tap_q == TAP_W'(NUM_TAPS - 1));
   assign centre     = nxt_end - TAP_W'(nxt_len >> 1);

   tws_ack_timer #(
      .LIMIT (ACK_LIMIT)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (upd_act),
      .ack_i    (tap_ack_i),
      .expire_o (expire)
   );

   tws_streak #(
      .TAP_W (TAP_W),
      .LEN_W (LEN_W)
   ) i_streak (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .hit_i     (hit),
      .miss_i    (miss),
      .tap_i     (tap_q),
      .nxt_len_o (nxt_len),
      .nxt_end_o (nxt_end)
   );

   always_comb begin
      st_d   = st_q;
      ph_d   = ph_q;
      fin_d  = fin_q;
      tap_d  = tap_q;
      done_d = 1'b0;
      err_d  = 1'b0;
      clr    = 1'b0;

      case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               st_d  = ST_UPD;
               ph_d  = 1'b0;
               fin_d = 1'b0;
               tap_d = '0;
               clr   = 1'b1;
            end
         end
         ST_UPD: begin
            if (tap_ack_i) begin
               if (!ph_q) begin
                  st_d = ST_GAP;
               end else if (fin_q) begin
                  st_d   = ST_IDLE;
                  done_d = 1'b1;
               end else begin
                  st_d = ST_TRIAL;
               end
            end else if (expire && fin_q) begin
               st_d  = ST_IDLE;
               err_d = 1'b1;
            end
         end
         ST_GAP: begin
            st_d = ST_UPD;
            ph_d = 1'b1;
         end
         default: begin
         end
      endcase

      if (step) begin
         ph_d = 1'b0;
         if (last_tap) begin
            if (nxt_len == '0) begin
               st_d  = ST_IDLE;
               err_d = 1'b1;
            end else begin
               st_d  = ST_UPD;
               tap_d = centre;
               fin_d = 1'b1;
            end
         end else begin
            st_d  = ST_UPD;
            tap_d = tap_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ph_q   <= 1'b0;
         fin_q  <= 1'b0;
         tap_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         ph_q   <= ph_d;
         fin_q  <= fin_d;
         tap_q  <= tap_d;
         done_q <= done_d;
         err_q  <= err_d;
      end
   end

   assign done_o      = done_q;
   assign err_o       = err_q;
   assign tap_o       = tap_q;
   assign tap_upd_o   = upd_act;
   assign trial_req_o = (st_q == ST_TRIAL);

endmodule

// File: rtl/tune_window_seq_chk.sv
module tune_window_seq_chk #(
   parameter int unsigned TAP_W    = 6,
   parameter int unsigned NUM_TAPS = 40
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             done_o,
   input logic             err_o,
   input logic [TAP_W-1:0] tap_o,
   input logic             tap_upd_o,
   input logic             tap_ack_i,
   input logic             trial_req_o,
   input logic             trial_vld_i
);

   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o)); // R10

   AST_UPD_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tap_upd_o && trial_req_o)); // R3

   AST_TRIAL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trial_req_o) |-> $past(tap_upd_o && tap_ack_i)); // R3

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (trial_req_o && !trial_vld_i) |=> trial_req_o); // R11

   AST_TAP_STEADY_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (trial_req_o && $past(trial_req_o)) |-> $stable(tap_o)); // R11

   AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(tap_upd_o && tap_ack_i)); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7

   AST_QUIET_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !start_i) |=> (!tap_upd_o && !trial_req_o)); // R8

   AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tap_o) < NUM_TAPS); // R2

endmodule

bind tune_window_seq tune_window_seq_chk #(
   .TAP_W    (TAP_W),
   .NUM_TAPS (NUM_TAPS)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .done_o      (done_o),
   .err_o       (err_o),
   .tap_o       (tap_o),
   .tap_upd_o   (tap_upd_o),
   .tap_ack_i   (tap_ack_i),
   .trial_req_o (trial_req_o),
   .trial_vld_i (trial_vld_i)
);

// File: tb/test_tune_window_seq.sv
module test_tune_window_seq;

   localparam int TW  = 6;
   localparam int NT  = 40;
   localparam int LIM = 250;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          done_o, err_o, tap_upd_o, trial_req_o;
   logic [TW-1:0] tap_o;
   logic          tap_ack_i = 1'b0;
   logic          trial_vld_i = 1'b0;
   logic          trial_pass_i = 1'b0;

   always #2 clk = ~clk;

   tune_window_seq #(.TAP_W(TW), .NUM_TAPS(NT), .ACK_LIMIT(LIM)) i_tune_window_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .err_o(err_o),
      .tap_o(tap_o), .tap_upd_o(tap_upd_o), .tap_ack_i(tap_ack_i),
      .trial_req_o(trial_req_o), .trial_vld_i(trial_vld_i), .trial_pass_i(trial_pass_i)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // stimulus knobs
   logic [NT-1:0] pat = '0;
   int  dead_tap = -1;
   bit  dead_final = 0;
   int  ack_dly = 0;
   int  trl_dly = 0;
   int  acnt = 0;
   int  tcnt = 0;
   int  trials = 0;

   // behavioural reference: phase 0 idle, 1 update, 2 gap, 3 trial
   int  ms = 0, mph = 0, mfin = 0, mtap = 0, mcur = 0, mbest = 0, mend = 0, mtmr = 0;
   bit  mdone = 0, merr = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic void m_advance();
      mph = 0;
      if (mtap == NT - 1) begin
         if (mbest == 0) begin
            merr = 1; ms = 0;
         end else begin
            mtap = mend - mbest / 2; mfin = 1; ms = 1;
         end
      end else begin
         mtap++; ms = 1;
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0; mph = 0; mfin = 0; mtap = 0; mcur = 0; mbest = 0; mend = 0; mtmr = 0;
         mdone = 0; merr = 0;
      end else begin
         mdone = 0; merr = 0;
         case (ms)
            0: if (start_i) begin
               ms = 1; mph = 0; mfin = 0; mtap = 0; mcur = 0; mbest = 0; mend = 0; mtmr = 0;
            end
            1: if (tap_ack_i) begin
               mtmr = 0;
               if (mph == 0) ms = 2;
               else if (mfin != 0) begin ms = 0; mdone = 1; end
               else ms = 3;
            end else if (mtmr == LIM - 1) begin
               mtmr = 0;
               if (mfin != 0) begin ms = 0; merr = 1; end
               else begin mcur = 0; m_advance(); end
            end else begin
               mtmr++;
            end
            2: begin ms = 1; mph = 1; end
            default: if (trial_vld_i) begin
               if (trial_pass_i) begin
                  mcur++;
                  if (mcur > mbest) begin mbest = mcur; mend = mtap; end
               end else begin
                  mcur = 0;
               end
               m_advance();
            end
         endcase
      end
   end

   // compare every cycle, then drive the responders
   always @(negedge clk) begin
      if (rst_n) begin
         chk(done_o == mdone, "R7", done_o, mdone);
         chk(err_o == merr, "R8", err_o, merr);
         chk(tap_upd_o == (ms == 1), "R3", tap_upd_o, ms == 1);
         chk(trial_req_o == (ms == 3), "R11", trial_req_o, ms == 3);
         chk(int'(tap_o) == mtap, "R2", tap_o, mtap);
      end
      if (tap_upd_o && !(mfin == 0 && int'(tap_o) == dead_tap) && !(mfin != 0 && dead_final)) begin
         tap_ack_i = (acnt >= ack_dly);
         acnt++;
      end else begin
         tap_ack_i = 1'b0;
         acnt = 0;
      end
      if (trial_req_o) begin
         trial_vld_i  = (tcnt >= trl_dly);
         trial_pass_i = pat[tap_o];
         if (tcnt == trl_dly) trials++;
         tcnt++;
      end else begin
         trial_vld_i  = 1'b0;
         trial_pass_i = 1'b0;
         tcnt = 0;
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
         finish_run();
      end
   end

   task automatic sweep(input string req, input int exp_tap, input bit exp_err,
                        input int exp_trials, input bit mid_start);
      bit seen = 0;
      trials = 0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (mid_start && i == 30) start_i = 1'b1;
         else start_i = 1'b0;
         if (done_o || err_o) begin seen = 1; break; end
      end
      chk(seen, req, seen, 1);
      chk(err_o == exp_err, exp_err ? "R8/R9 error pulse" : "R7 done pulse", err_o, exp_err);
      chk(done_o == !exp_err, "R10 done/err", done_o, !exp_err);
      if (!exp_err) chk(int'(tap_o) == exp_tap, req, tap_o, exp_tap);
      chk(trials == exp_trials, "R2 trial count", trials, exp_trials);
      @(negedge clk);
      chk(!done_o && !err_o && !tap_upd_o && !trial_req_o, "R7 single pulse, idle", done_o | err_o, 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!done_o && !err_o && !tap_upd_o && !trial_req_o && tap_o == '0, "R1 reset", tap_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!tap_upd_o && !trial_req_o, "R1 idle", tap_upd_o, 0);

      // R5 R6: best run 5..14, shorter run 20..22 -> 14 - 5 = 9
      pat = '0; pat[14:5] = '1; pat[22:20] = '1;
      sweep("R6 centre of longest run", 9, 0, NT, 0);

      // R5: equal runs 3..6 and 20..23, earlier kept -> 6 - 2 = 4
      pat = '0; pat[6:3] = '1; pat[23:20] = '1; ack_dly = 3; trl_dly = 2;
      sweep("R5 tie keeps earlier", 4, 0, NT, 0);

      // R8: nothing passes
      pat = '0; ack_dly = 0; trl_dly = 0;
      sweep("R8 no pass", 0, 1, NT, 0);

      // R6: all pass -> 39 - 20 = 19
      pat = '1;
      sweep("R6 all pass", 19, 0, NT, 0);

      // R4 R10: dead commit at tap 12 splits 10..20, mid-sweep start ignored -> 20 - 4 = 16
      pat = '0; pat[20:10] = '1; dead_tap = 12; ack_dly = 1;
      sweep("R4 update timeout splits run", 16, 0, NT - 1, 1);
      dead_tap = -1; ack_dly = 0;

      // R6: odd length 7..9 -> 9 - 1 = 8
      pat = '0; pat[9:7] = '1; trl_dly = 1;
      sweep("R6 odd length rounds down", 8, 0, NT, 0);

      // R6: single pass at last tap
      pat = '0; pat[NT-1] = 1'b1; trl_dly = 0;
      sweep("R6 single tap at end", NT - 1, 0, NT, 0);

      // R9: final commit never acknowledged
      pat = '0; pat[14:5] = '1; dead_final = 1;
      sweep("R9 final commit timeout", 0, 1, NT, 0);
      dead_final = 0;

      // R3: a normal sweep after the error path
      pat = '0; pat[30:25] = '1; ack_dly = 2;
      sweep("R3 recovery sweep", 27, 0, NT, 0);

      finish_run();
   end

endmodule